// File: doc/BRIEF.md
# Synchronous SRAM with Sleep Control

This block puts a small single-port synchronous memory behind a power-state gate. An external agent raises an asynchronous, active-high sleep request. The block passes that request through a two-flop synchroniser and then spends a fixed number of cycles entering sleep. While it is asleep, every command pin is ignored, the read-data drivers are disabled and the array keeps its contents.

When the request falls, the block passes through a fixed wake-up window. During that window it accepts reads and deselects but refuses writes. A write issued during sleep or wake-up does not reach the array and raises a one-cycle status pulse. A separate pulse warns when sleep begins while a command is being issued or read data is still in flight. Reads return data one cycle after the command.

An undriven request pin is to be tied low at the pad, so the block treats it as inactive in normal use.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: The first cycle after reset shows the following values: `ready`=1, `sleeping`=0, `rd_oe`=0, `rd_data`=0, `illegal_cmd`=0 and `inflight_hazard`=0.
- R2: A read (`cs`=1, `we`=0) accepted while awake places the addressed word on `rd_data` with `rd_oe`=1 in the next cycle. A deselect cycle (`cs`=0) gives `rd_oe`=0 and `rd_data`=0 in the cycle after it.
- R3: After `sleep_req` rises, `ready` falls on the third rising clock edge and `sleeping` rises on the fifth. That is two synchroniser cycles, one cycle to leave the awake state and two entry cycles.
- R4: While asleep, reads and writes have no effect: `rd_oe` stays 0, `rd_data` stays 0 and the array is unchanged.
- R5: After `sleep_req` falls, `sleeping` drops on the third rising edge and `ready` rises on the fifth. The two cycles in between form the wake-up window.
- R6: A write issued during the wake-up window does not change the array. A read issued in the last wake-up cycle is accepted, and its data appears with `rd_oe`=1 in the first awake cycle.
- R7: A write (`cs`=1, `we`=1) issued while asleep or waking drives `illegal_cmd` high for the following cycle.
- R8: The array contents written before sleep are returned unchanged by reads after wake-up.
- R9: `inflight_hazard` is high for one cycle, the first entry cycle, when the synchronised request is seen while `cs` is high or read data is pending. It stays low when sleep starts from an idle interface.

Ports, in the order of the port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| cs | input | 1 | Chip select; 0 means deselect |
| we | input | 1 | Write enable when selected (1 = write, 0 = read) |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, zero when the drivers are disabled |
| rd_oe | output | 1 | Read-data driver enable |
| ready | output | 1 | High when the block is awake |
| sleeping | output | 1 | High when the block is asleep |
| illegal_cmd | output | 1 | One-cycle pulse after a refused write |
| inflight_hazard | output | 1 | One-cycle pulse when sleep starts over a pending command |

## Verification
Two functions can fall in the same cycle: sleep entry and an ongoing command. The bench provokes this by holding a read selected while raising the request. It then expects `inflight_hazard` exactly on the third edge and nowhere else, and it compares this against a sleep entry from an idle interface, where the pulse must stay low. The wake-up window is treated the same way. A write and then a read are issued in its two cycles. The refused write must leave the old word in place, and the read must still deliver that word in the first awake cycle.

// File: rtl/sram_zz_pkg.sv
package sram_zz_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE    = 2'd0,
        ST_ENTERING = 2'd1,
        ST_ASLEEP   = 2'd2,
        ST_WAKING   = 2'd3
    } pwr_state_t;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic wr_bad;
    } cmd_gate_t;

    // Decide which parts of a command may act in a given power state.
    function automatic cmd_gate_t gate_cmd(pwr_state_t st, logic sel, logic wr);
        cmd_gate_t g;
        g.wr_ok  = sel && wr  && (st == ST_AWAKE || st == ST_ENTERING);
        g.rd_ok  = sel && !wr && (st == ST_AWAKE || st == ST_WAKING);
        g.wr_bad = sel && wr  && (st == ST_ASLEEP || st == ST_WAKING);
        return g;
    endfunction

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import sram_zz_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int WAKE_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_s,
    output pwr_state_t state
);
    localparam int MAX_CYC = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC) + 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_AWAKE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_AWAKE: begin
                    if (req_s) begin
                        state <= ST_ENTERING;
                        cnt   <= '0;
                    end
                end
                ST_ENTERING: begin
                    if (cnt == CNT_W'(ENTRY_CYC - 1)) begin
                        state <= ST_ASLEEP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ASLEEP: begin
                    if (!req_s) begin
                        state <= ST_WAKING;
                        cnt   <= '0;
                    end
                end
                ST_WAKING: begin
                    if (cnt == CNT_W'(WAKE_CYC - 1)) begin
                        state <= ST_AWAKE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_AWAKE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (rd_en) q <= mem[addr];
    end
endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
    import sram_zz_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int WAKE_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output logic              ready,
    output logic              sleeping,
    output logic              illegal_cmd,
    output logic              inflight_hazard
);
    logic              req_s;
    pwr_state_t        state;
    cmd_gate_t         gate;
    logic [DATA_W-1:0] arr_q;
    logic              rd_q;

    sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sleep_req),
        .sync_out (req_s)
    );

    sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .req_s (req_s),
        .state (state)
    );

    assign gate = gate_cmd(state, cs, we);

    sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .wr_en (gate.wr_ok),
        .rd_en (gate.rd_ok),
        .addr  (addr),
        .wdata (wdata),
        .q     (arr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q            <= 1'b0;
            illegal_cmd     <= 1'b0;
            inflight_hazard <= 1'b0;
        end else begin
            rd_q            <= gate.rd_ok;
            illegal_cmd     <= gate.wr_bad;
            inflight_hazard <= (state == ST_AWAKE) && req_s && (cs || rd_q);
        end
    end

    assign rd_oe    = rd_q && (state == ST_AWAKE);
    assign rd_data  = rd_oe ? arr_q : '0;
    assign ready    = (state == ST_AWAKE);
    assign sleeping = (state == ST_ASLEEP);

    // R2
    oe_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> $past(cs && !we));

    // R3
    asleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sleeping) |-> $past(state) == ST_ENTERING);

    // R4
    asleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_ASLEEP) |-> ($stable(arr_q) && !rd_oe));

    // R5
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(state) == ST_WAKING);

    // R7
    illegal_src_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_cmd |-> $past(cs && we && (state == ST_ASLEEP || state == ST_WAKING)));

    // R9
    inflight_state_chk: assert property (@(posedge clk) disable iff (rst)
        inflight_hazard |-> state == ST_ENTERING);
endmodule

// File: tb/sram_sleep_ctrl_bench.sv
module sram_sleep_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_req = 1'b0;
    logic          cs = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic          rd_oe, ready, sleeping, illegal_cmd, inflight_hazard;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    sram_sleep_ctrl u_sram_sleep_ctrl (
        .clk             (clk),
        .rst             (rst),
        .sleep_req       (sleep_req),
        .cs              (cs),
        .we              (we),
        .addr            (addr),
        .wdata           (wdata),
        .rd_data         (rd_data),
        .rd_oe           (rd_oe),
        .ready           (ready),
        .sleeping        (sleeping),
        .illegal_cmd     (illegal_cmd),
        .inflight_hazard (inflight_hazard)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic idle();
        cs = 1'b0;
        we = 1'b0;
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        tick();
        idle();
    endtask

    task automatic read_expect(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
        cs = 1'b1; we = 1'b0; addr = a;
        tick();
        idle();
        check({tag, " oe"}, 32'(rd_oe), 32'd1);
        check({tag, " data"}, 32'(rd_data), 32'(exp));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R1 ready", 32'(ready), 32'd1);
        check("R1 sleeping", 32'(sleeping), 32'd0);
        check("R1 rd_oe", 32'(rd_oe), 32'd0);
        check("R1 rd_data", 32'(rd_data), 32'd0);
        check("R1 illegal", 32'(illegal_cmd), 32'd0);
        check("R1 inflight", 32'(inflight_hazard), 32'd0);
    endtask

    task automatic t_basic_rw();
        do_write(6'd1, 16'h1111);
        do_write(6'd2, 16'hA5A5);
        do_write(6'd63, 16'h5A0F);
        read_expect("R2 addr1", 6'd1, 16'h1111);
        read_expect("R2 addr2", 6'd2, 16'hA5A5);
        read_expect("R2 addr63", 6'd63, 16'h5A0F);
        tick();
        check("R2 deselect oe", 32'(rd_oe), 32'd0);
        check("R2 deselect data", 32'(rd_data), 32'd0);
    endtask

    task automatic t_entry();
        sleep_req = 1'b1;
        tick(); tick();
        check("R3 ready after 2 edges", 32'(ready), 32'd1);
        tick();
        check("R3 ready after 3 edges", 32'(ready), 32'd0);
        check("R9 idle entry no hazard", 32'(inflight_hazard), 32'd0);
        tick();
        check("R3 sleeping after 4 edges", 32'(sleeping), 32'd0);
        tick();
        check("R3 sleeping after 5 edges", 32'(sleeping), 32'd1);
    endtask

    task automatic t_asleep();
        cs = 1'b1; we = 1'b1; addr = 6'd1; wdata = 16'hBEEF;
        tick();
        idle();
        check("R7 write asleep pulse", 32'(illegal_cmd), 32'd1);
        check("R4 oe asleep", 32'(rd_oe), 32'd0);
        tick();
        check("R7 pulse ends", 32'(illegal_cmd), 32'd0);
        cs = 1'b1; we = 1'b0; addr = 6'd2;
        tick();
        idle();
        check("R4 read asleep oe", 32'(rd_oe), 32'd0);
        check("R4 read asleep data", 32'(rd_data), 32'd0);
        check("R4 still sleeping", 32'(sleeping), 32'd1);
    endtask

    task automatic t_wake();
        sleep_req = 1'b0;
        tick(); tick();
        check("R5 sleeping after 2 edges", 32'(sleeping), 32'd1);
        tick();
        check("R5 sleeping after 3 edges", 32'(sleeping), 32'd0);
        check("R5 ready during wake", 32'(ready), 32'd0);
        cs = 1'b1; we = 1'b1; addr = 6'd1; wdata = 16'hDEAD;
        tick();
        check("R7 write waking pulse", 32'(illegal_cmd), 32'd1);
        check("R5 ready after 4 edges", 32'(ready), 32'd0);
        cs = 1'b1; we = 1'b0; addr = 6'd1;
        tick();
        idle();
        check("R5 ready after 5 edges", 32'(ready), 32'd1);
        check("R6 read in wake oe", 32'(rd_oe), 32'd1);
        check("R6 write in wake blocked", 32'(rd_data), 32'h1111);
        tick();
    endtask

    task automatic t_retention();
        read_expect("R8 addr2", 6'd2, 16'hA5A5);
        read_expect("R8 addr63", 6'd63, 16'h5A0F);
        read_expect("R8 addr1", 6'd1, 16'h1111);
        tick();
    endtask

    task automatic t_inflight();
        cs = 1'b1; we = 1'b0; addr = 6'd2;
        sleep_req = 1'b1;
        tick(); tick();
        check("R9 hazard before sync", 32'(inflight_hazard), 32'd0);
        tick();
        check("R9 hazard raised", 32'(inflight_hazard), 32'd1);
        tick();
        idle();
        check("R9 hazard one cycle", 32'(inflight_hazard), 32'd0);
        tick();
        check("R3 asleep after hazard", 32'(sleeping), 32'd1);
        sleep_req = 1'b0;
        repeat (5) tick();
        check("R5 awake again", 32'(ready), 32'd1);
        read_expect("R8 addr2 final", 6'd2, 16'hA5A5);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic_rw();
        t_entry();
        t_asleep();
        t_wake();
        t_retention();
        t_inflight();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule